// File: doc/BRIEF.md
# Baud-Rate Tick and Clock-Out Generator

This block turns a 16-bit reload counter into a shared timing source. While running, it advances once every state time, which is two oscillator clocks. When it passes its all-ones value it loads a value written by software. That rollover makes a one-cycle baud tick for the receive side of a serial port, for the transmit side, or for both, depending on two select inputs. The same rollover also toggles a clock-out pin, which gives a 50% duty output of oscillator / (4 × (65536 − reload)). Because there is one reload value, baud rate and clock-out frequency cannot be chosen separately.

An event-count option replaces the state-time step with the falling edges of an event pin. This option also turns clock-out off. A separate external pin can set a sticky event flag, but it never reloads the counter. Rollover never raises an overflow indication of any kind. Software can load the count and reload values at any time. Writes made while the counter is running are accepted, but they are not safe to rely on.

The serial shifter that uses the ticks sits outside this block.

Top module: `baud_clkgen`

## Requirements
- R1: After a synchronous reset, count, reload, both ticks, clk_out and ext_flag are all 0.
- R2: With run=1, evt_mode=0 and rx_sel or tx_sel set, the count rises by exactly 1 every two clocks. After run is raised, the first step lands on the second rising edge.
- R3: A step taken at count all-ones loads the current reload value instead of incrementing. The ticks therefore repeat every 2 × (65536 − reload) clocks.
- R4: tx_tick and rx_tick are one-clock pulses in the cycle right after a rollover. Each is gated by its own select input: tx_sel for tx_tick, rx_sel for rx_tick.
- R5: Rollover never sets ext_flag.
- R6: When ext_en=1, a 1-to-0 transition on ext_pin sets ext_flag on the next edge. The flag stays set until ext_clr, and a set in the same cycle wins over a clear. The transition does not disturb the count or its reload period. When ext_en=0, ext_pin is ignored.
- R7: With clk_oe=1 and evt_mode=0, clk_out toggles on every rollover, so each half period is 2 × (65536 − reload) clocks. With clk_oe=0, clk_out is held at 0. run=1 with clk_oe alone is enough to start the counter, and run=0 freezes both count and clk_out.
- R8: With evt_mode=1, clock-out is off: clk_out is 0, and clk_oe alone does not start the counter.
- R9: Baud ticks and clock-out share the one reload value. When both are enabled, clk_out changes in the same cycle that a tick pulses.
- R10: With evt_mode=1 and a select bit set, the count steps once for each falling edge of evt_pin. Phases of evt_pin must each last at least two clocks.
- R11: A cnt_we write takes priority over a step or reload in the same cycle. A rollover in the same cycle as an rld_we write loads the old reload value. The new reload value is used from the next rollover on.
- R12: With run=1 but no select bit set and clock-out off, the count stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start/stop of the counter |
| rx_sel | input | 1 | Enables the receive baud tick and baud mode |
| tx_sel | input | 1 | Enables the transmit baud tick and baud mode |
| evt_mode | input | 1 | 1 = count evt_pin falling edges, 0 = count state times |
| clk_oe | input | 1 | Clock-out enable |
| ext_en | input | 1 | Enables ext_pin edge detection |
| ext_pin | input | 1 | External event pin (sets flag only) |
| ext_clr | input | 1 | Clears ext_flag |
| evt_pin | input | 1 | Event input used when evt_mode=1 |
| cnt_we | input | 1 | Count load strobe |
| cnt_wdata | input | CNT_W | Count load value |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | CNT_W | Reload register write value |
| count | output | CNT_W | Current count |
| reload | output | CNT_W | Current reload value |
| tx_tick | output | 1 | Transmit baud tick |
| rx_tick | output | 1 | Receive baud tick |
| clk_out | output | 1 | 50% duty clock output |
| ext_flag | output | 1 | Sticky external event flag |

## Verification
A falling edge on ext_pin can land in the same cycle as a rollover. The bench provokes this with a short period of four clocks, setting reload to 0xFFFE. It drops ext_pin at each of the four clock phases that follow a tick. Each time, it judges that ext_flag gets set and that the gap to the next tick is still four clocks, which shows the edge caused no reload. Tick and clock-out edges also coincide by design. In the reload sweep the bench checks that clk_out changes in exactly the cycle a tick pulses.

// File: rtl/baud_clkgen_pkg.sv
package baud_clkgen_pkg;

    typedef struct packed {
        logic run;
        logic rx_sel;
        logic tx_sel;
        logic evt_mode;
        logic clk_oe;
    } bcg_cfg_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_STATE = 2'd1,
        SRC_EVENT = 2'd2
    } bcg_src_t;

    localparam int unsigned N_TICK = 2;
    localparam int unsigned TICK_TX = 0;
    localparam int unsigned TICK_RX = 1;

    function automatic logic baud_on(bcg_cfg_t c);
        return c.rx_sel | c.tx_sel;
    endfunction

    function automatic logic clko_on(bcg_cfg_t c);
        return c.clk_oe & ~c.evt_mode;
    endfunction

    function automatic bcg_src_t pick_src(bcg_cfg_t c);
        bcg_src_t s;
        s = SRC_NONE;
        if (c.run) begin
            if (c.evt_mode) begin
                if (baud_on(c)) s = SRC_EVENT;
            end else if (baud_on(c) || clko_on(c)) begin
                s = SRC_STATE;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/bcg_stepgen.sv
module bcg_stepgen
    import baud_clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bcg_cfg_t cfg,
    input  logic     evt_pin,
    output logic     step
);
    bcg_src_t src;
    logic     phase;
    logic     evt_q1;
    logic     evt_q2;
    logic     evt_fall;

    assign src = pick_src(cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else if (src == SRC_STATE) begin
            phase <= ~phase;
        end else begin
            phase <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q1 <= 1'b0;
            evt_q2 <= 1'b0;
        end else begin
            evt_q1 <= evt_pin;
            evt_q2 <= evt_q1;
        end
    end

    assign evt_fall = evt_q2 & ~evt_q1;

    always_comb begin
        unique case (src)
            SRC_STATE: step = phase;
            SRC_EVENT: step = evt_fall;
            default:   step = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcg_counter.sv
module bcg_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             roll
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign roll = step & ~cnt_we & (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
        end else if (rld_we) begin
            reload <= rld_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_we) begin
            count <= cnt_wdata;
        end else if (roll) begin
            count <= reload;
        end else if (step) begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/bcg_outputs.sv
module bcg_outputs
    import baud_clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bcg_cfg_t cfg,
    input  logic     roll,
    output logic     tx_tick,
    output logic     rx_tick,
    output logic     clk_out
);
    logic [N_TICK-1:0] sel;
    logic [N_TICK-1:0] tick_q;

    assign sel[TICK_TX] = cfg.tx_sel;
    assign sel[TICK_RX] = cfg.rx_sel;

    for (genvar i = 0; i < N_TICK; i++) begin : g_tick
        always_ff @(posedge clk) begin
            if (rst) begin
                tick_q[i] <= 1'b0;
            end else begin
                tick_q[i] <= roll & sel[i];
            end
        end
    end

    assign tx_tick = tick_q[TICK_TX];
    assign rx_tick = tick_q[TICK_RX];

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_out <= 1'b0;
        end else if (!clko_on(cfg)) begin
            clk_out <= 1'b0;
        end else if (roll) begin
            clk_out <= ~clk_out;
        end
    end
endmodule

// File: rtl/bcg_extflag.sv
module bcg_extflag (
    input  logic clk,
    input  logic rst,
    input  logic ext_en,
    input  logic ext_pin,
    input  logic ext_clr,
    output logic ext_flag
);
    logic pin_q;
    logic fall;

    assign fall = pin_q & ~ext_pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b0;
            ext_flag <= 1'b0;
        end else begin
            pin_q <= ext_pin;
            if (ext_en && fall) begin
                ext_flag <= 1'b1;
            end else if (ext_clr) begin
                ext_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
    import baud_clkgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             rx_sel,
    input  logic             tx_sel,
    input  logic             evt_mode,
    input  logic             clk_oe,
    input  logic             ext_en,
    input  logic             ext_pin,
    input  logic             ext_clr,
    input  logic             evt_pin,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             tx_tick,
    output logic             rx_tick,
    output logic             clk_out,
    output logic             ext_flag
);
    bcg_cfg_t cfg;
    logic     step;
    logic     roll;

    always_comb begin
        cfg.run      = run;
        cfg.rx_sel   = rx_sel;
        cfg.tx_sel   = tx_sel;
        cfg.evt_mode = evt_mode;
        cfg.clk_oe   = clk_oe;
    end

    bcg_stepgen u_step (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .evt_pin (evt_pin),
        .step    (step)
    );

    bcg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .rld_we    (rld_we),
        .rld_wdata (rld_wdata),
        .count     (count),
        .reload    (reload),
        .roll      (roll)
    );

    bcg_outputs u_out (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .roll    (roll),
        .tx_tick (tx_tick),
        .rx_tick (rx_tick),
        .clk_out (clk_out)
    );

    bcg_extflag u_ext (
        .clk      (clk),
        .rst      (rst),
        .ext_en   (ext_en),
        .ext_pin  (ext_pin),
        .ext_clr  (ext_clr),
        .ext_flag (ext_flag)
    );
endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             rx_sel,
    input logic             tx_sel,
    input logic             evt_mode,
    input logic             clk_oe,
    input logic             ext_en,
    input logic             ext_pin,
    input logic             cnt_we,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             tx_tick,
    input logic             rx_tick,
    input logic             clk_out,
    input logic             ext_flag
);
    // R3: a tick follows a reload from the value held before that edge
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (tx_tick && !$past(cnt_we)) |-> (count == $past(reload)));

    // R2: without a write, the count only steps by one or reloads
    a_r2_step_or_reload: assert property (@(posedge clk) disable iff (rst)
        (!$stable(count) && !$past(cnt_we)) |->
            ((count == CNT_W'($past(count) + CNT_W'(1))) || (count == $past(reload))));

    // R4: ticks are single-cycle pulses and gated by their own select
    a_r4_tx_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_tick |=> !tx_tick);
    a_r4_rx_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_tick |=> !rx_tick);
    a_r4_tx_gated: assert property (@(posedge clk) disable iff (rst)
        tx_tick |-> $past(tx_sel));
    a_r4_rx_gated: assert property (@(posedge clk) disable iff (rst)
        rx_tick |-> $past(rx_sel));

    // R6 and R5: the flag only rises after an enabled ext_pin fall
    a_r6_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_flag) |-> ($past(ext_en) && !$past(ext_pin) && $past(ext_pin, 2)));

    // R7 and R8: clk_out rises only while clock-out is on and running
    a_r7_clk_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> $past(run && clk_oe && !evt_mode));

    // R12: nothing selected keeps the count still
    a_r12_idle: assert property (@(posedge clk) disable iff (rst)
        (!rx_sel && !tx_sel && !(clk_oe && !evt_mode) && !cnt_we) |=> $stable(count));
endmodule

bind baud_clkgen baud_clkgen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .rx_sel   (rx_sel),
    .tx_sel   (tx_sel),
    .evt_mode (evt_mode),
    .clk_oe   (clk_oe),
    .ext_en   (ext_en),
    .ext_pin  (ext_pin),
    .cnt_we   (cnt_we),
    .count    (count),
    .reload   (reload),
    .tx_tick  (tx_tick),
    .rx_tick  (rx_tick),
    .clk_out  (clk_out),
    .ext_flag (ext_flag)
);

// File: tb/baud_clkgen_tb_top.sv
module baud_clkgen_tb_top;
    localparam int CLK_P = 10;
    localparam int W = 16;
    localparam int LIMIT = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 0, rx_sel = 0, tx_sel = 0, evt_mode = 0, clk_oe = 0;
    logic ext_en = 0, ext_pin = 1, ext_clr = 0, evt_pin = 0;
    logic cnt_we = 0, rld_we = 0;
    logic [W-1:0] cnt_wdata = '0, rld_wdata = '0;
    logic [W-1:0] count, reload;
    logic tx_tick, rx_tick, clk_out, ext_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    baud_clkgen #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .run(run), .rx_sel(rx_sel), .tx_sel(tx_sel),
        .evt_mode(evt_mode), .clk_oe(clk_oe), .ext_en(ext_en), .ext_pin(ext_pin),
        .ext_clr(ext_clr), .evt_pin(evt_pin), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .rld_we(rld_we), .rld_wdata(rld_wdata), .count(count), .reload(reload),
        .tx_tick(tx_tick), .rx_tick(rx_tick), .clk_out(clk_out), .ext_flag(ext_flag)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] c, input logic [W-1:0] r);
        cnt_we = 1; cnt_wdata = c; rld_we = 1; rld_wdata = r;
        cyc(1);
        cnt_we = 0; rld_we = 0;
    endtask

    task automatic stop_all();
        run = 0; rx_sel = 0; tx_sel = 0; clk_oe = 0; evt_mode = 0;
        cyc(2);
    endtask

    // ends on a negedge with tx_tick high; g = clocks since the previous one
    task automatic gap_tx(output int g);
        int n;
        n = 0;
        cyc(1);
        while (tx_tick !== 1'b1 && n < LIMIT) begin cyc(1); n++; end
        n = 0;
        do begin cyc(1); n++; end while (tx_tick !== 1'b1 && n < LIMIT);
        g = (n < LIMIT) ? n : -1;
    endtask

    task automatic half_clk(output int g);
        int n;
        logic v;
        n = 0;
        v = clk_out;
        while (clk_out === v && n < LIMIT) begin cyc(1); n++; end
        v = clk_out;
        n = 0;
        do begin cyc(1); n++; end while (clk_out === v && n < LIMIT);
        g = (n < LIMIT) ? n : -1;
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int g;
        int ntx;
        int nrx;
        logic prev;
        logic ok;
        logic [W-1:0] r;
        logic [W-1:0] hold;

        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        check("R1 count", count, 0);
        check("R1 reload", reload, 0);
        check("R1 ticks", {tx_tick, rx_tick}, 0);
        check("R1 clk_out", clk_out, 0);
        check("R1 ext_flag", ext_flag, 0);

        // R2 step rate
        load(16'h1000, 16'h0000);
        rx_sel = 1; run = 1;
        cyc(1);
        check("R2 no step on first edge", count, 16'h1000);
        cyc(9);
        check("R2 count after 10 clocks", count, 16'h1005);
        stop_all();

        // R3 R4 R7 R9 R5 sweep over the last eight reload values
        ext_en = 1; ext_pin = 1;
        for (int k = 1; k <= 8; k++) begin
            r = W'(65536 - k);
            load(r, r);
            tx_sel = 1; clk_oe = 1; run = 1;
            gap_tx(g);
            check($sformatf("R3 tick gap k=%0d", k), g, 2 * k);
            check($sformatf("R3 count reloaded k=%0d", k), count, r);
            check($sformatf("R4 rx gated off k=%0d", k), rx_tick, 0);
            half_clk(g);
            check($sformatf("R7 clk_out half period k=%0d", k), g, 2 * k);
            ok = 0;
            prev = clk_out;
            for (int i = 0; i < 40 && !ok; i++) begin
                cyc(1);
                if (tx_tick === 1'b1) begin
                    ok = 1;
                    check($sformatf("R9 clk_out toggles with tick k=%0d", k), clk_out, !prev);
                end
                prev = clk_out;
            end
            check($sformatf("R9 tick seen k=%0d", k), ok, 1);
            run = 0;
            cyc(1);
            hold = count; prev = clk_out;
            cyc(6);
            check($sformatf("R7 run=0 freezes count k=%0d", k), count, hold);
            check($sformatf("R7 run=0 freezes clk_out k=%0d", k), clk_out, prev);
            stop_all();
        end
        check("R5 no flag from rollovers", ext_flag, 0);

        // R4 rx tick alone over a window
        load(16'hFFF8, 16'hFFF8);
        rx_sel = 1; run = 1;
        g = 0;
        while (rx_tick !== 1'b1 && g < LIMIT) begin cyc(1); g++; end
        ntx = 0; nrx = 0;
        for (int i = 0; i < 160; i++) begin
            cyc(1);
            if (tx_tick === 1'b1) ntx++;
            if (rx_tick === 1'b1) nrx++;
        end
        check("R4 rx ticks in 160 clocks", nrx, 10);
        check("R4 tx silent", ntx, 0);
        check("R7 clk_out low with clk_oe=0", clk_out, 0);
        stop_all();

        // R6 ext pin at each phase relative to a rollover, period 4
        load(16'hFFFE, 16'hFFFE);
        tx_sel = 1; run = 1;
        for (int ph = 0; ph < 4; ph++) begin
            gap_tx(g);
            cyc(ph);
            ext_pin = 0;
            cyc(1);
            check($sformatf("R6 flag set ph=%0d", ph), ext_flag, 1);
            ext_pin = 1;
            gap_tx(g);
            check($sformatf("R6 gap intact ph=%0d", ph), g, 4);
            ext_clr = 1;
            cyc(1);
            ext_clr = 0;
            check($sformatf("R6 flag cleared ph=%0d", ph), ext_flag, 0);
        end
        // R6 set wins over clear
        ext_pin = 0; ext_clr = 1;
        cyc(1);
        ext_clr = 0; ext_pin = 1;
        check("R6 set beats clear", ext_flag, 1);
        ext_clr = 1; cyc(1); ext_clr = 0;
        // R6 ignored when disabled
        ext_en = 0; ext_pin = 0;
        cyc(3);
        check("R6 ignored with ext_en=0", ext_flag, 0);
        ext_pin = 1;
        cyc(2);
        stop_all();

        // R8 event mode disables clock-out
        load(16'h4000, 16'h0000);
        evt_mode = 1; clk_oe = 1; run = 1;
        cyc(10);
        check("R8 count idle", count, 16'h4000);
        check("R8 clk_out off", clk_out, 0);
        stop_all();

        // R10 event counting
        load(16'h2000, 16'h0000);
        evt_mode = 1; rx_sel = 1; run = 1; evt_pin = 0;
        cyc(3);
        for (int i = 0; i < 5; i++) begin
            evt_pin = 1; cyc(3);
            evt_pin = 0; cyc(3);
        end
        cyc(3);
        check("R10 five falling edges", count, 16'h2005);
        stop_all();

        // R12 run with nothing selected
        load(16'h0777, 16'h0000);
        run = 1;
        cyc(10);
        check("R12 count still", count, 16'h0777);
        stop_all();

        // R11 write priority while running
        load(16'h0100, 16'h0000);
        tx_sel = 1; run = 1;
        cyc(3);
        cnt_we = 1; cnt_wdata = 16'h3456;
        cyc(1);
        cnt_we = 0;
        check("R11 count write wins", count, 16'h3456);
        cnt_we = 1; cnt_wdata = 16'hFFF0;
        rld_we = 1; rld_wdata = 16'h1234;
        cyc(1);
        cnt_we = 0; rld_we = 0;
        g = 0;
        while (tx_tick !== 1'b1 && g < LIMIT) begin cyc(1); g++; end
        check("R11 new reload used", count, 16'h1234);
        stop_all();
        // R11 rollover coinciding with a reload write uses the old value
        load(16'hFFFF, 16'h00AA);
        tx_sel = 1; run = 1;
        cyc(1);
        rld_we = 1; rld_wdata = 16'h00BB;
        cyc(1);
        rld_we = 0;
        check("R11 tick on rollover", tx_tick, 1);
        check("R11 old reload loaded", count, 16'h00AA);
        check("R11 reload updated", reload, 16'h00BB);
        stop_all();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule